// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block sits on the device side of a DDR2 SDRAM command bus. On every rising clock edge it samples chip select, the three command strobes, the bank address and the address lines. It classifies the sampled command, keeps an open flag and an open-row value for each bank, and works out whether a precharge closes one bank or all of them and whether a read or write carries auto-precharge. It also writes mode-register op-codes and follows the power state that the clock-enable input drives.

The block is meant for a memory model or for a monitor that follows a controller's command stream. It reports the decoded command as a one-cycle code, raises a one-cycle illegal flag for commands that do not fit the current bank state, and presents the open state of each bank, the row held by each bank, all mode registers and the current power state. It does not check timing between commands, carry data or strobes, or model termination.

The same address bit has a different meaning for each command, and the bank-address field names a mode register rather than a bank during a mode load. Which power-down state the block enters depends on whether any bank has a row open.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: When `cs_n` is sampled high, the command is ignored. `cmd_kind` reads 0 (no operation) after that edge, `illegal` stays low, and no bank or mode register changes.
- R2: An ACTIVATE ({ras_n,cas_n,we_n}=011) to an idle bank sets `bank_open[ba]` and stores `addr` in that bank's row slot `bank_rows[ba*14 +: 14]`. `cmd_kind` reads 1.
- R3: A READ (101) or WRITE (100) to an open bank reads `cmd_kind` 2 or 4 and leaves the bank open. With `addr[10]` high, it reads 3 or 5 and closes the addressed bank.
- R4: A PRECHARGE (010) with `addr[10]` low closes only bank `ba` and reads `cmd_kind` 6. With `addr[10]` high it closes every bank and reads 7.
- R5: A LOAD MODE (000) with `ba` from 0 to 3 writes `addr` into mode register `ba`, held at `mode_regs[ba*14 +: 14]`, and reads `cmd_kind` 9. A `ba` of 4 or more raises `illegal` and writes nothing.
- R6: An ACTIVATE to an open bank, or a READ or WRITE to an idle bank, pulses `illegal` for one cycle, reads `cmd_kind` 0 and leaves every bank unchanged.
- R7: A REFRESH (001) with clock enable high and all banks idle reads `cmd_kind` 8. A REFRESH while any bank is open raises `illegal`.
- R8: When `cke` is sampled low in the running state (`pwr_state` 0) and the edge does not start self refresh, the block enters precharge power-down (1) if all banks are idle and active power-down (2) otherwise.
- R9: A REFRESH sampled with `cke` low while all banks are idle enters self refresh (`pwr_state` 3) and reads `cmd_kind` 10.
- R10: In power-down or self refresh, every command is ignored. The first edge with `cke` high returns the block to the running state, and the command sampled on that edge is also ignored.
- R11: In self refresh, `pwr_state` reads 0 as soon as `cke` is high, before the next clock edge.
- R12: A synchronous reset closes all banks, clears all mode registers to zero, sets `pwr_state` to 0, sets `cmd_kind` to 0 and clears `illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 3 | Bank address, or mode-register select during a mode load |
| addr | input | 14 | Row address, column address with auto-precharge bit 10, or op-code |
| cmd_kind | output | 4 | Code of the command accepted on the last edge |
| illegal | output | 1 | One-cycle flag for a command rejected on the last edge |
| bank_open | output | 8 | One bit per bank, high while a row is open |
| bank_rows | output | 112 | Row held by each bank, 14 bits per bank |
| mode_regs | output | 56 | Four mode registers, 14 bits each |
| pwr_state | output | 2 | 0 running, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
Decoding is driven with row opens across several banks, then reads and writes with bit 10 low and high. This separates plain accesses from auto-precharge closes and checks that only the addressed bank changes. Precharges with bit 10 low and high are issued while two banks are open, so a single-bank close shows up as a surviving neighbour. Mode loads with four different op-codes show that each select value reaches its own register. Power entry is tried with banks idle, with a bank open, and with a refresh command, which separates the three low-power states. Commands issued during those states, and on the exit edge, show that they are ignored. In self refresh, clock enable is raised between edges so that the early exit report is seen before the clock edge.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

    typedef enum logic [3:0] {
        K_NOP  = 4'd0,
        K_ACT  = 4'd1,
        K_RD   = 4'd2,
        K_RDA  = 4'd3,
        K_WR   = 4'd4,
        K_WRA  = 4'd5,
        K_PRE  = 4'd6,
        K_PREA = 4'd7,
        K_REF  = 4'd8,
        K_LMR  = 4'd9,
        K_SRE  = 4'd10
    } cmd_kind_e;

    typedef enum logic [1:0] {
        PWR_RUN    = 2'd0,
        PWR_PRE_PD = 2'd1,
        PWR_ACT_PD = 2'd2,
        PWR_SELF   = 2'd3
    } pwr_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    // Map the three strobes plus the auto-precharge / all-bank bit to a kind.
    function automatic cmd_kind_e classify_pins(input logic ras_n, input logic cas_n,
                                                input logic we_n, input logic ap);
        cmd_kind_e k;
        case ({ras_n, cas_n, we_n})
            3'b011:  k = K_ACT;
            3'b101:  k = ap ? K_RDA : K_RD;
            3'b100:  k = ap ? K_WRA : K_WR;
            3'b010:  k = ap ? K_PREA : K_PRE;
            3'b001:  k = K_REF;
            3'b000:  k = K_LMR;
            default: k = K_NOP;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ddr2_cmd_classify.sv
module ddr2_cmd_classify
    import ddr2_trk_pkg::*;
(
    input  strobe_t   pins,
    input  logic      ap_bit,
    output cmd_kind_e raw_kind
);
    always_comb begin
        if (pins.cs_n)
            raw_kind = K_NOP;
        else
            raw_kind = classify_pins(pins.ras_n, pins.cas_n, pins.we_n, ap_bit);
    end
endmodule

// File: rtl/ddr2_bank_table.sv
module ddr2_bank_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       open_en,
    input  logic [BA_W-1:0]            open_bank,
    input  logic [ROW_W-1:0]           open_row,
    input  logic                       close_one,
    input  logic [BA_W-1:0]            close_bank,
    input  logic                       close_all,
    output logic [NUM_BANKS-1:0]       open_vec,
    output logic [NUM_BANKS*ROW_W-1:0] row_flat
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;
        logic             hit_close;
        logic             hit_open;

        assign hit_close = close_all || (close_one && (close_bank == BA_W'(b)));
        assign hit_open  = open_en && (open_bank == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (hit_close) begin
                open_r <= 1'b0;
            end else if (hit_open) begin
                open_r <= 1'b1;
                row_r  <= open_row;
            end
        end

        assign open_vec[b]                  = open_r;
        assign row_flat[b*ROW_W +: ROW_W]   = row_r;
    end
endmodule

// File: rtl/ddr2_mode_regs.sv
module ddr2_mode_regs #(
    parameter int NUM_MR = 4,
    parameter int OP_W   = 14,
    localparam int SEL_W = $clog2(NUM_MR)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [OP_W-1:0]        wr_data,
    output logic [NUM_MR*OP_W-1:0] regs_flat
);
    for (genvar m = 0; m < NUM_MR; m++) begin : g_mr
        logic [OP_W-1:0] val_r;

        always_ff @(posedge clk) begin
            if (rst)
                val_r <= '0;
            else if (wr_en && (wr_sel == SEL_W'(m)))
                val_r <= wr_data;
        end

        assign regs_flat[m*OP_W +: OP_W] = val_r;
    end
endmodule

// File: rtl/ddr2_power_fsm.sv
module ddr2_power_fsm
    import ddr2_trk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic any_open,
    input  logic ref_req,
    output pwr_e state_q,
    output pwr_e state_seen,
    output logic run_cycle,
    output logic sr_enter,
    output logic pd_enter
);
    pwr_e state_d;

    assign run_cycle = (state_q == PWR_RUN) && cke;
    assign sr_enter  = (state_q == PWR_RUN) && !cke && ref_req && !any_open;
    assign pd_enter  = (state_q == PWR_RUN) && !cke && !sr_enter;

    always_comb begin
        state_d = state_q;
        case (state_q)
            PWR_RUN: begin
                if (sr_enter)
                    state_d = PWR_SELF;
                else if (pd_enter)
                    state_d = any_open ? PWR_ACT_PD : PWR_PRE_PD;
            end
            PWR_PRE_PD, PWR_ACT_PD, PWR_SELF: begin
                if (cke)
                    state_d = PWR_RUN;
            end
            default: state_d = PWR_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PWR_RUN;
        else
            state_q <= state_d;
    end

    // Self-refresh exit is reported as soon as clock enable rises.
    assign state_seen = (state_q == PWR_SELF && cke) ? PWR_RUN : state_q;
endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
    import ddr2_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 14,
    parameter int NUM_MR    = 4,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int MR_SEL_W = $clog2(NUM_MR)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        cke,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [3:0]                  cmd_kind,
    output logic                        illegal,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] bank_rows,
    output logic [NUM_MR*ADDR_W-1:0]    mode_regs,
    output logic [1:0]                  pwr_state
);
    strobe_t   pins;
    cmd_kind_e raw_kind;
    cmd_kind_e kind_d, kind_q;
    logic      ill_d, ill_q;
    logic      any_open, ref_req;
    logic      run_cycle, sr_enter, pd_enter;
    pwr_e      st_q, st_seen;
    logic      open_en, close_one, close_all, mr_wr;
    logic      target_open;

    assign pins        = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};
    assign any_open    = |bank_open;
    assign ref_req     = (raw_kind == K_REF);
    assign target_open = bank_open[ba];

    ddr2_cmd_classify u_classify (
        .pins     (pins),
        .ap_bit   (addr[AP_BIT]),
        .raw_kind (raw_kind)
    );

    ddr2_power_fsm u_power (
        .clk        (clk),
        .rst        (rst),
        .cke        (cke),
        .any_open   (any_open),
        .ref_req    (ref_req),
        .state_q    (st_q),
        .state_seen (st_seen),
        .run_cycle  (run_cycle),
        .sr_enter   (sr_enter),
        .pd_enter   (pd_enter)
    );

    // Accept or reject the sampled command against the current bank state.
    always_comb begin
        kind_d    = K_NOP;
        ill_d     = 1'b0;
        open_en   = 1'b0;
        close_one = 1'b0;
        close_all = 1'b0;
        mr_wr     = 1'b0;
        if (run_cycle) begin
            case (raw_kind)
                K_ACT: begin
                    if (target_open) ill_d = 1'b1;
                    else begin
                        open_en = 1'b1;
                        kind_d  = K_ACT;
                    end
                end
                K_RD, K_RDA, K_WR, K_WRA: begin
                    if (!target_open) ill_d = 1'b1;
                    else begin
                        kind_d    = raw_kind;
                        close_one = (raw_kind == K_RDA) || (raw_kind == K_WRA);
                    end
                end
                K_PRE: begin
                    close_one = 1'b1;
                    kind_d    = K_PRE;
                end
                K_PREA: begin
                    close_all = 1'b1;
                    kind_d    = K_PREA;
                end
                K_REF: begin
                    if (any_open) ill_d = 1'b1;
                    else kind_d = K_REF;
                end
                K_LMR: begin
                    if (int'(ba) >= NUM_MR) ill_d = 1'b1;
                    else begin
                        mr_wr  = 1'b1;
                        kind_d = K_LMR;
                    end
                end
                default: kind_d = K_NOP;
            endcase
        end else if (sr_enter) begin
            kind_d = K_SRE;
        end else if (pd_enter && ref_req && any_open) begin
            ill_d = 1'b1;
        end
    end

    ddr2_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ADDR_W)
    ) u_banks (
        .clk        (clk),
        .rst        (rst),
        .open_en    (open_en),
        .open_bank  (ba),
        .open_row   (addr),
        .close_one  (close_one),
        .close_bank (ba),
        .close_all  (close_all),
        .open_vec   (bank_open),
        .row_flat   (bank_rows)
    );

    ddr2_mode_regs #(
        .NUM_MR (NUM_MR),
        .OP_W   (ADDR_W)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (mr_wr),
        .wr_sel    (ba[MR_SEL_W-1:0]),
        .wr_data   (addr),
        .regs_flat (mode_regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= K_NOP;
            ill_q  <= 1'b0;
        end else begin
            kind_q <= kind_d;
            ill_q  <= ill_d;
        end
    end

    assign cmd_kind  = kind_q;
    assign illegal   = ill_q;
    assign pwr_state = st_seen;
endmodule

// File: rtl/ddr2_trk_checker.sv
module ddr2_trk_checker
    import ddr2_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic [3:0]           cmd_kind,
    input logic                 illegal,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [1:0]           pwr_state
);
    // R1: a deselected edge yields no command and no flag
    a_r1_deselect_nop: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (cmd_kind == K_NOP) && !illegal);

    // R2: an accepted ACTIVATE opens exactly one more bank
    a_r2_act_adds_one: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == K_ACT) |-> ($countones(bank_open) == $countones($past(bank_open)) + 1));

    // R3: auto-precharge access closes exactly one bank
    a_r3_ap_closes_one: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == K_RDA || cmd_kind == K_WRA)
        |-> ($countones(bank_open) + 1 == $countones($past(bank_open))));

    // R4: all-bank precharge leaves nothing open
    a_r4_prea_all_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == K_PREA) |-> (bank_open == '0));

    // R6: a rejected command leaves the bank table as it was
    a_r6_illegal_no_change: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (bank_open == $past(bank_open)));

    // R8: precharge power-down only with all banks idle
    a_r8_pre_pd_idle: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_PRE_PD) |-> (bank_open == '0));

    // R8: active power-down only with a bank open
    a_r8_act_pd_open: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_ACT_PD) |-> (bank_open != '0));

    // R9: self refresh only with all banks idle
    a_r9_self_idle: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_SELF) |-> (bank_open == '0));

    // R10: while in power-down, bank state holds
    a_r10_pd_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(pwr_state) != PWR_RUN && pwr_state != PWR_RUN) |-> $stable(bank_open));
endmodule

bind ddr2_cmd_tracker ddr2_trk_checker #(.NUM_BANKS(NUM_BANKS)) u_trk_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .cmd_kind  (cmd_kind),
    .illegal   (illegal),
    .bank_open (bank_open),
    .pwr_state (pwr_state)
);

// File: tb/tb_ddr2_cmd_tracker.sv
`timescale 1ns/1ps
module tb_ddr2_cmd_tracker;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1111;

    logic         clk = 1'b0;
    logic         rst;
    logic         cs_n, ras_n, cas_n, we_n, cke;
    logic [2:0]   ba;
    logic [13:0]  addr;
    logic [3:0]   cmd_kind;
    logic         illegal;
    logic [7:0]   bank_open;
    logic [111:0] bank_rows;
    logic [55:0]  mode_regs;
    logic [1:0]   pwr_state;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ddr2_cmd_tracker dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr), .cmd_kind(cmd_kind), .illegal(illegal),
        .bank_open(bank_open), .bank_rows(bank_rows), .mode_regs(mode_regs),
        .pwr_state(pwr_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] c, input logic k, input logic [2:0] b,
                            input logic [13:0] a);
        {cs_n, ras_n, cas_n, we_n} = c;
        cke  = k;
        ba   = b;
        addr = a;
    endtask

    task automatic issue(input logic [3:0] c, input logic k, input logic [2:0] b,
                         input logic [13:0] a);
        @(negedge clk);
        set_pins(c, k, b, a);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        set_pins(C_NOP, 1'b1, 3'd0, 14'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R12 bank_open", bank_open, 0);
        check("R12 mode_regs", mode_regs[31:0], 0);
        check("R12 pwr_state", pwr_state, 0);
        check("R12 cmd_kind", cmd_kind, 0);
        check("R12 illegal", illegal, 0);
    endtask

    task automatic t_r1_deselect();
        issue(C_DES & 4'b1011 | 4'b1000, 1'b1, 3'd2, 14'h0055); // cs high, ACT strobes
        check("R1 kind", cmd_kind, 0);
        check("R1 bank_open", bank_open, 0);
        issue({1'b1, C_LMR[2:0]}, 1'b1, 3'd1, 14'h3ABC);
        check("R1 mode_regs", mode_regs[27:14], 0);
    endtask

    task automatic t_r2_r3_access();
        issue(C_ACT, 1'b1, 3'd3, 14'h1234);
        check("R2 kind", cmd_kind, 1);
        check("R2 open", bank_open, 8'h08);
        check("R2 row", bank_rows[3*14 +: 14], 14'h1234);
        issue(C_RD, 1'b1, 3'd3, 14'h0010);
        check("R3 rd kind", cmd_kind, 2);
        check("R3 rd open", bank_open, 8'h08);
        issue(C_WR, 1'b1, 3'd3, 14'h0020);
        check("R3 wr kind", cmd_kind, 4);
        issue(C_ACT, 1'b1, 3'd6, 14'h0777);
        issue(C_WR, 1'b1, 3'd3, 14'h0400);
        check("R3 wra kind", cmd_kind, 5);
        check("R3 wra close", bank_open, 8'h40);
        issue(C_RD, 1'b1, 3'd6, 14'h0401);
        check("R3 rda kind", cmd_kind, 3);
        check("R3 rda close", bank_open, 8'h00);
    endtask

    task automatic t_r4_precharge();
        issue(C_ACT, 1'b1, 3'd1, 14'h0011);
        issue(C_ACT, 1'b1, 3'd2, 14'h0022);
        issue(C_PRE, 1'b1, 3'd1, 14'h0000);
        check("R4 pre kind", cmd_kind, 6);
        check("R4 pre one", bank_open, 8'h04);
        issue(C_ACT, 1'b1, 3'd7, 14'h0033);
        issue(C_PRE, 1'b1, 3'd0, 14'h0400);
        check("R4 prea kind", cmd_kind, 7);
        check("R4 prea all", bank_open, 8'h00);
    endtask

    task automatic t_r5_load_mode();
        for (int i = 0; i < 4; i++) begin
            issue(C_LMR, 1'b1, 3'(i), 14'(16'h0101 * (i + 1)));
            check("R5 kind", cmd_kind, 9);
        end
        for (int i = 0; i < 4; i++)
            check("R5 reg", mode_regs[i*14 +: 14], 14'(16'h0101 * (i + 1)));
        issue(C_LMR, 1'b1, 3'd5, 14'h3FFF);
        check("R5 bad sel illegal", illegal, 1);
        check("R5 bad sel untouched", mode_regs[13:0], 14'h0101);
    endtask

    task automatic t_r6_illegal();
        issue(C_RD, 1'b1, 3'd4, 14'h0000);
        check("R6 rd closed illegal", illegal, 1);
        check("R6 rd closed kind", cmd_kind, 0);
        issue(C_ACT, 1'b1, 3'd4, 14'h0AAA);
        check("R6 illegal clears", illegal, 0);
        issue(C_ACT, 1'b1, 3'd4, 14'h0BBB);
        check("R6 act open illegal", illegal, 1);
        check("R6 row kept", bank_rows[4*14 +: 14], 14'h0AAA);
        issue(C_WR, 1'b1, 3'd0, 14'h0400);
        check("R6 wr closed illegal", illegal, 1);
        check("R6 banks kept", bank_open, 8'h10);
    endtask

    task automatic t_r7_refresh();
        issue(C_REF, 1'b1, 3'd0, 14'h0000);
        check("R7 ref open illegal", illegal, 1);
        issue(C_PRE, 1'b1, 3'd0, 14'h0400);
        issue(C_REF, 1'b1, 3'd0, 14'h0000);
        check("R7 ref kind", cmd_kind, 8);
        check("R7 ref legal", illegal, 0);
    endtask

    task automatic t_r8_r10_powerdown();
        issue(C_NOP, 1'b0, 3'd0, 14'h0000);
        check("R8 pre pd", pwr_state, 1);
        issue(C_ACT, 1'b0, 3'd2, 14'h0123);
        check("R10 pd ignore", bank_open, 8'h00);
        issue(C_ACT, 1'b1, 3'd2, 14'h0123);
        check("R10 exit run", pwr_state, 0);
        check("R10 exit cmd ignored", bank_open, 8'h00);
        issue(C_ACT, 1'b1, 3'd5, 14'h0321);
        issue(C_NOP, 1'b0, 3'd0, 14'h0000);
        check("R8 act pd", pwr_state, 2);
        issue(C_PRE, 1'b0, 3'd0, 14'h0400);
        check("R10 act pd ignore", bank_open, 8'h20);
        issue(C_NOP, 1'b1, 3'd0, 14'h0000);
        check("R10 act pd exit", pwr_state, 0);
        issue(C_PRE, 1'b1, 3'd0, 14'h0400);
    endtask

    task automatic t_r9_r11_selfref();
        issue(C_REF, 1'b0, 3'd0, 14'h0000);
        check("R9 self state", pwr_state, 3);
        check("R9 sre kind", cmd_kind, 10);
        issue(C_ACT, 1'b0, 3'd1, 14'h0042);
        check("R10 sr ignore", bank_open, 8'h00);
        check("R10 sr stays", pwr_state, 3);
        @(negedge clk);
        set_pins(C_ACT, 1'b1, 3'd1, 14'h0042);
        #1;
        check("R11 early exit", pwr_state, 0);
        @(posedge clk);
        #1;
        check("R10 sr exit cmd ignored", bank_open, 8'h00);
        issue(C_ACT, 1'b1, 3'd1, 14'h0042);
        check("R10 run after exit", bank_open, 8'h02);
    endtask

    task automatic t_r12_reset_clears();
        do_reset();
        @(posedge clk);
        #1;
        check("R12 banks cleared", bank_open, 0);
        check("R12 modes cleared", mode_regs[55:28], 0);
        check("R12 rows cleared", bank_rows[1*14 +: 14], 0);
    endtask

    initial begin
        rst = 1'b1;
        set_pins(C_NOP, 1'b1, 3'd0, 14'd0);
        t_reset_state();
        t_r1_deselect();
        t_r2_r3_access();
        t_r4_precharge();
        t_r5_load_mode();
        t_r6_illegal();
        t_r7_refresh();
        t_r8_r10_powerdown();
        t_r9_r11_selfref();
        t_r12_reset_clears();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule